// File: doc/BRIEF.md
# Protected Power-Control Register Guard

This block holds two power-control registers and one system configuration register behind a small register bus. Until the end of initialisation every register is freely writable. Once the initialisation pulse has been seen, the configuration register is frozen for good. The two power-control registers can then only be changed through a keyed unlock procedure.

The key lives in a 4-bit release field at the bottom of control register A, and that field stays writable at all times. Three qualified writes must leave the field holding the right value at each step. The third step is normally a single-bit set. After a correct key, exactly one write to either control register goes through, with its write mask applied, and the lock then closes again. Every step and the granted write must carry the extended-space qualifier. A wrong step, a write elsewhere, or loss of the qualifier drops the procedure back to idle.

An attempt to change locked bits without a grant is dropped quietly and raises a sticky violation flag.

Top module: `pwr_guard`

## Requirements
- R1: Reset (synchronous, active low) clears all three registers, the read data, `locked`, `unlocked` and `violation` to 0.
- R2: The register addresses are 0xF1D0 for control A, 0xF1D4 for control B and 0xFF12 for the system configuration register. Before the initialisation pulse, a write to any of them updates exactly the bits set in `bus_wmask`, with or without the qualifier.
- R3: From the cycle after `init_done` is seen, `locked` is 1 until reset. Without a grant, bits 15:4 of control A and all of control B ignore writes.
- R4: Bits 3:0 of control A (the release field) accept masked writes at all times, locked or not.
- R5: With `bus_ext` high throughout, three writes to control A that leave the release field at 1001b, then 0011b, then 0111b set `unlocked` to 1 in the cycle after the third write.
- R6: While `unlocked` is 1, the first qualified write to control A or B is applied in full under its mask. `unlocked` is 0 from the next cycle, and later writes are locked out again.
- R7: A granted or pre-initialisation write changes only the bits set in the mask. For example, data 0x2900 under mask 0x7F00 changes only bits 14:8 of control A.
- R8: A key step with the wrong field value, a qualified write to any other address, or any cycle with `bus_ext` low returns the sequence to idle with no grant. Writing 0000b to the field is therefore a clean restart.
- R9: After initialisation the system configuration register never changes, even while `unlocked` is 1. A qualified write to it in that state ends the unlocked window.
- R10: When `bus_rd` is high, `bus_rdata` shows the addressed register from the next cycle, whatever the lock state. An unmapped address reads as 0.
- R11: A write, without a grant, whose mask touches a locked bit (after initialisation) sets `violation`. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_wmask | input | 16 | Per-bit write enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_ext | input | 1 | Extended-space / atomic window qualifier |
| init_done | input | 1 | End-of-initialisation pulse |
| bus_rdata | output | 16 | Registered read data |
| ctrl_a_q | output | 16 | Control register A contents |
| ctrl_b_q | output | 16 | Control register B contents |
| sys_cfg_q | output | 16 | System configuration register contents |
| locked | output | 1 | Initialisation has ended |
| unlocked | output | 1 | One write is currently granted |
| violation | output | 1 | Sticky blocked-write flag |

## Verification
Timing follows one rule: every result of this block is due one clock edge after its stimulus. Register contents, `locked`, `violation` and `unlocked` change at the edge that samples the write or pulse, and `bus_rdata` changes at the edge that samples `bus_rd`. The bench sets each stimulus at a falling edge, removes it at the next falling edge, and compares the outputs at that moment, so exactly one rising edge separates cause and check. The bench sweeps all sixteen values of the first key step and of the second key step, runs masked writes across every nibble before initialisation, and tracks a model of the three registers built from the masking rule.

// File: rtl/guard_pkg.sv
// Package guard_pkg
// Shared types and constants for the protected register guard.
// Assumes the release field sits in the low bits of control register A.
package guard_pkg;

    localparam int KEY_W = 4;

    // Field values the three key steps must leave behind, in order
    localparam logic [KEY_W-1:0] KEY_STEP1 = 4'b1001;
    localparam logic [KEY_W-1:0] KEY_STEP2 = 4'b0011;
    localparam logic [KEY_W-1:0] KEY_STEP3 = 4'b0111;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_STEP1 = 2'd1,
        SEQ_STEP2 = 2'd2,
        SEQ_OPEN  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/guard_key_fsm.sv
// Module guard_key_fsm
// Tracks progress through the three-step release key. It judges each step by
// the field value a write leaves behind, so a single-bit set counts as a step.
// Assumes key_next is the post-write field value of control register A.
// Any cycle with the qualifier low returns to idle. Any qualified write while
// open ends the window, whether or not it was granted.
module guard_key_fsm
    import guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_wr,
    input  logic             qual,
    input  logic             hit_key_reg,
    input  logic [KEY_W-1:0] key_next,
    output logic             is_open
);

    seq_state_t state_q, state_d;

    // Next-state decode for the key sequence
    always_comb begin
        state_d = state_q;
        if (!qual) begin
            state_d = SEQ_IDLE;
        end else if (step_wr) begin
            case (state_q)
                SEQ_IDLE:  state_d = (hit_key_reg && key_next == KEY_STEP1) ? SEQ_STEP1 : SEQ_IDLE;
                SEQ_STEP1: state_d = (hit_key_reg && key_next == KEY_STEP2) ? SEQ_STEP2 : SEQ_IDLE;
                SEQ_STEP2: state_d = (hit_key_reg && key_next == KEY_STEP3) ? SEQ_OPEN  : SEQ_IDLE;
                default:   state_d = SEQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign is_open = (state_q == SEQ_OPEN);

endmodule

// File: rtl/guard_reg.sv
// Module guard_reg
// One masked-write register with a lock. Bits in FREE_MASK always take
// writes. The remaining bits take writes only while allow is high.
// blocked flags a write that tried to touch a locked bit.
module guard_reg #(
    parameter int          DATA_W    = 16,
    parameter logic [15:0] FREE_MASK = '0,
    parameter logic [15:0] RST_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              allow,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] q,
    output logic              blocked
);

    localparam logic [DATA_W-1:0] FREE = FREE_MASK[DATA_W-1:0];

    logic [DATA_W-1:0] eff_mask;

    // Bits this write may change
    always_comb begin
        eff_mask = allow ? wmask : (wmask & FREE);
    end

    // Register storage with masked update
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL[DATA_W-1:0];
        else if (we) q <= (q & ~eff_mask) | (wdata & eff_mask);
    end

    assign blocked = we && !allow && (|(wmask & ~FREE));

endmodule

// File: rtl/guard_rd_port.sv
// Module guard_rd_port
// Registered read port. It takes the one-hot address decode and returns the
// selected register one cycle after the read strobe. Unmapped addresses read 0.
// Holds its output between reads.
module guard_rd_port #(
    parameter int DATA_W = 16,
    parameter int NREG   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [NREG-1:0]   hit,
    input  logic [DATA_W-1:0] vals [NREG],
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    // AND-OR selection of the addressed register
    always_comb begin
        sel = '0;
        for (int i = 0; i < NREG; i++) begin
            sel |= vals[i] & {DATA_W{hit[i]}};
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end

endmodule

// File: rtl/pwr_guard.sv
// Module pwr_guard (top)
// Holds two power-control registers and a system configuration register.
// Before init_done, all writes are free. After it, the configuration register
// is frozen and the control registers take one write per correct release key.
// Assumes a single write or read per cycle. init_done is treated as sticky.
module pwr_guard
    import guard_pkg::*;
#(
    parameter int                DATA_W = 16,
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ADDR_A = 16'hF1D0,
    parameter logic [ADDR_W-1:0] ADDR_B = 16'hF1D4,
    parameter logic [ADDR_W-1:0] ADDR_C = 16'hFF12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_wmask,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ext,
    input  logic              init_done,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] ctrl_a_q,
    output logic [DATA_W-1:0] ctrl_b_q,
    output logic [DATA_W-1:0] sys_cfg_q,
    output logic              locked,
    output logic              unlocked,
    output logic              violation
);

    localparam int NREG = 3;
    localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{ADDR_A, ADDR_B, ADDR_C};
    localparam logic [15:0] KEY_MASK = 16'((1 << KEY_W) - 1);

    logic [NREG-1:0]   hit;
    logic [NREG-1:0]   allow;
    logic [NREG-1:0]   blocked;
    logic [DATA_W-1:0] reg_q [NREG];
    logic              init_seen;
    logic              seq_open;
    logic              grant;
    logic              viol_q;
    logic [KEY_W-1:0]  key_next;

    // Address decode for each register
    always_comb begin
        for (int i = 0; i < NREG; i++) hit[i] = (bus_addr == REG_ADDR[i]);
    end

    // Remember that initialisation has ended
    always_ff @(posedge clk) begin
        if (!rst_n)         init_seen <= 1'b0;
        else if (init_done) init_seen <= 1'b1;
    end

    // One granted write: qualified, window open, to a control register
    assign grant = bus_wr && bus_ext && seq_open && (hit[0] || hit[1]);

    // Write permission per register
    always_comb begin
        allow[0] = !init_seen || grant;
        allow[1] = !init_seen || grant;
        allow[2] = !init_seen;
    end

    // Field value left behind by this write to control register A
    always_comb begin
        key_next = (reg_q[0][KEY_W-1:0] & ~bus_wmask[KEY_W-1:0])
                 | (bus_wdata[KEY_W-1:0] & bus_wmask[KEY_W-1:0]);
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            guard_reg #(
                .DATA_W    (DATA_W),
                .FREE_MASK ((g == 0) ? KEY_MASK : 16'h0000),
                .RST_VAL   (16'h0000)
            ) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (bus_wr && hit[g]),
                .allow   (allow[g]),
                .wdata   (bus_wdata),
                .wmask   (bus_wmask),
                .q       (reg_q[g]),
                .blocked (blocked[g])
            );
        end
    endgenerate

    guard_key_fsm u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_wr     (bus_wr),
        .qual        (bus_ext),
        .hit_key_reg (hit[0]),
        .key_next    (key_next),
        .is_open     (seq_open)
    );

    guard_rd_port #(
        .DATA_W (DATA_W),
        .NREG   (NREG)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .hit   (hit),
        .vals  (reg_q),
        .rdata (bus_rdata)
    );

    // Sticky violation flag
    always_ff @(posedge clk) begin
        if (!rst_n)        viol_q <= 1'b0;
        else if (|blocked) viol_q <= 1'b1;
    end

    assign ctrl_a_q  = reg_q[0];
    assign ctrl_b_q  = reg_q[1];
    assign sys_cfg_q = reg_q[2];
    assign locked    = init_seen;
    assign unlocked  = seq_open;
    assign violation = viol_q;

endmodule

// File: rtl/pwr_guard_chk.sv
// Module pwr_guard_chk
// Temporal checks on the guard's ports, bound to every pwr_guard instance.
module pwr_guard_chk #(
    parameter int                DATA_W = 16,
    parameter int                ADDR_W = 16,
    parameter int                KEY_W  = 4,
    parameter logic [ADDR_W-1:0] ADDR_A = 16'hF1D0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_ext,
    input logic [DATA_W-1:0] ctrl_a_q,
    input logic [DATA_W-1:0] ctrl_b_q,
    input logic [DATA_W-1:0] sys_cfg_q,
    input logic              locked,
    input logic              unlocked,
    input logic              violation
);

    // R11
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R5
    unlock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_ext && bus_addr == ADDR_A));

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_ext) |=> !unlocked);

    // R8
    qual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ext |=> !unlocked);

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sys_cfg_q));

    // R3
    ctrl_b_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(unlocked && bus_wr && bus_ext)) |=> $stable(ctrl_b_q));

    // R3
    ctrl_a_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !(unlocked && bus_wr && bus_ext)) |=> $stable(ctrl_a_q[DATA_W-1:KEY_W]));

endmodule

bind pwr_guard pwr_guard_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .KEY_W  (4),
    .ADDR_A (ADDR_A)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_ext   (bus_ext),
    .ctrl_a_q  (ctrl_a_q),
    .ctrl_b_q  (ctrl_b_q),
    .sys_cfg_q (sys_cfg_q),
    .locked    (locked),
    .unlocked  (unlocked),
    .violation (violation)
);

// File: tb/tb_pwr_guard.sv
// Bench tb_pwr_guard: sweeps key steps and masked writes against a bench
// model of the three registers. Inputs change on falling edges; outputs are
// compared one falling edge later.
module tb_pwr_guard;

    localparam logic [15:0] A_ADR = 16'hF1D0;
    localparam logic [15:0] B_ADR = 16'hF1D4;
    localparam logic [15:0] C_ADR = 16'hFF12;
    localparam logic [15:0] NOWHERE = 16'h1234;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0, bus_wmask = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_ext = 1'b0, init_done = 1'b0;
    logic [15:0] bus_rdata, ctrl_a_q, ctrl_b_q, sys_cfg_q;
    logic        locked, unlocked, violation;

    int checks = 0;
    int fails  = 0;
    logic [15:0] ma = '0, mb = '0, mc = '0;

    always #10 clk = ~clk;

    pwr_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ext(bus_ext),
        .init_done(init_done), .bus_rdata(bus_rdata), .ctrl_a_q(ctrl_a_q),
        .ctrl_b_q(ctrl_b_q), .sys_cfg_q(sys_cfg_q), .locked(locked),
        .unlocked(unlocked), .violation(violation)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [15:0] d, input logic [15:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [15:0] m);
        return (old & ~m) | (d & m);
    endfunction

    task automatic check_regs(input string tag);
        check(tag, ctrl_a_q, ma);
        check(tag, ctrl_b_q, mb);
        check(tag, sys_cfg_q, mc);
    endtask

    // Correct three-step key with qualifier held; updates the model field
    task automatic unlock_seq();
        bus_ext = 1'b1;
        do_wr(A_ADR, 16'h0000, 16'h000F);
        do_wr(A_ADR, 16'h0009, 16'h000F);
        do_wr(A_ADR, 16'h0003, 16'h000F);
        do_wr(A_ADR, 16'h0004, 16'h0004);
        ma = (ma & 16'hFFF0) | 16'h0007;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_regs("R1 regs after reset");
        check("R1 locked", locked, 0);
        check("R1 unlocked", unlocked, 0);
        check("R1 violation", violation, 0);
        check("R1 rdata", bus_rdata, 0);

        // R2 / R7: free masked writes before initialisation
        for (int i = 0; i < 16; i++) begin
            for (int g = 0; g < 3; g++) begin
                logic [15:0] d, m, a;
                d = 16'hA5C3 ^ 16'(i * 16'h1111) ^ 16'(g * 16'h0F0F);
                m = 16'(16'hF << (4 * (i % 4))) | ((i >= 8) ? 16'h8001 : 16'h0000);
                a = (g == 0) ? A_ADR : (g == 1) ? B_ADR : C_ADR;
                bus_ext = i[0];
                do_wr(a, d, m);
                if (g == 0) ma = merge(ma, d, m);
                else if (g == 1) mb = merge(mb, d, m);
                else mc = merge(mc, d, m);
                check_regs("R2 R7 pre-init masked write");
            end
        end
        bus_ext = 1'b0;
        check("R2 no violation before init", violation, 0);

        // R10 reads
        rd_chk("R10 read A", A_ADR, ma);
        rd_chk("R10 read B", B_ADR, mb);
        rd_chk("R10 read C", C_ADR, mc);
        rd_chk("R10 read unmapped", NOWHERE, 16'h0000);

        // R3 initialisation pulse
        @(negedge clk); init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
        check("R3 locked after init", locked, 1);

        // R4 release field writable while locked, no violation
        do_wr(A_ADR, 16'hFFF5, 16'h000F);
        ma = merge(ma, 16'hFFF5, 16'h000F);
        check("R4 key field write", ctrl_a_q, ma);
        check("R11 key write no violation", violation, 0);

        // R3 / R11 locked writes ignored and flagged
        do_wr(B_ADR, 16'hFFFF, 16'hFFFF);
        check("R3 B locked", ctrl_b_q, mb);
        check("R11 violation set", violation, 1);
        do_wr(A_ADR, 16'h0000, 16'hFFFF);
        ma = merge(ma, 16'h0000, 16'h000F);
        check("R3 R4 A upper locked", ctrl_a_q, ma);
        do_wr(C_ADR, 16'h0000, 16'hFFFF);
        check("R9 C locked", sys_cfg_q, mc);
        rd_chk("R10 read while locked", B_ADR, mb);

        // R5 / R8 sweep of first key step
        for (int v = 0; v < 16; v++) begin
            bus_ext = 1'b1;
            do_wr(A_ADR, 16'h0000, 16'h000F);
            do_wr(A_ADR, 16'(v), 16'h000F);
            do_wr(A_ADR, 16'h0003, 16'h000F);
            do_wr(A_ADR, 16'h0004, 16'h0004);
            check("R5 R8 first-step sweep", unlocked, (v == 9) ? 1 : 0);
            do_wr(NOWHERE, 16'hFFFF, 16'hFFFF);
            check("R8 other address closes", unlocked, 0);
            ma = (ma & 16'hFFF0) | 16'h0007;
        end
        check_regs("R8 no grant from sweep");

        // R5 / R8 sweep of second key step
        for (int w = 0; w < 16; w++) begin
            bus_ext = 1'b1;
            do_wr(A_ADR, 16'h0000, 16'h000F);
            do_wr(A_ADR, 16'h0009, 16'h000F);
            do_wr(A_ADR, 16'(w), 16'h000F);
            do_wr(A_ADR, 16'h0004, 16'h0004);
            check("R5 R8 second-step sweep", unlocked, (w == 3) ? 1 : 0);
            do_wr(NOWHERE, 16'h0000, 16'h0000);
            ma = (ma & 16'hFFF0) | 16'(w | 4);
        end

        // R6 / R7 granted masked write to A
        unlock_seq();
        check("R5 unlocked before grant", unlocked, 1);
        do_wr(A_ADR, 16'h2900, 16'h7F00);
        ma = merge(ma, 16'h2900, 16'h7F00);
        check("R6 R7 granted A write", ctrl_a_q, ma);
        check("R6 window closed", unlocked, 0);
        do_wr(A_ADR, 16'hFFFF, 16'hFF00);
        check("R6 second write ignored", ctrl_a_q, ma);

        // R6 granted write to B
        unlock_seq();
        do_wr(B_ADR, 16'h1234, 16'hFFFF);
        mb = 16'h1234;
        check("R6 granted B write", ctrl_b_q, mb);
        check("R6 closed after B", unlocked, 0);

        // R8 qualifier dropped mid-sequence
        bus_ext = 1'b1;
        do_wr(A_ADR, 16'h0009, 16'h000F);
        do_wr(A_ADR, 16'h0003, 16'h000F);
        @(negedge clk); bus_ext = 1'b0;
        @(negedge clk); bus_ext = 1'b1;
        do_wr(A_ADR, 16'h0004, 16'h0004);
        check("R8 qualifier loss", unlocked, 0);

        // R8 step without qualifier does not advance
        do_wr(A_ADR, 16'h0000, 16'h000F);
        bus_ext = 1'b0;
        do_wr(A_ADR, 16'h0009, 16'h000F);
        bus_ext = 1'b1;
        do_wr(A_ADR, 16'h0003, 16'h000F);
        do_wr(A_ADR, 16'h0004, 16'h0004);
        check("R8 unqualified step", unlocked, 0);

        // R8 write elsewhere mid-sequence
        do_wr(A_ADR, 16'h0000, 16'h000F);
        do_wr(A_ADR, 16'h0009, 16'h000F);
        do_wr(B_ADR, 16'h0000, 16'h0000);
        do_wr(A_ADR, 16'h0003, 16'h000F);
        do_wr(A_ADR, 16'h0004, 16'h0004);
        check("R8 foreign write aborts", unlocked, 0);

        // R8 writing 0000 restarts, then a clean key works
        do_wr(A_ADR, 16'h0009, 16'h000F);
        do_wr(A_ADR, 16'h0003, 16'h000F);
        do_wr(A_ADR, 16'h0000, 16'h000F);
        check("R8 zero write idles", unlocked, 0);
        unlock_seq();
        check("R8 clean restart unlocks", unlocked, 1);

        // R9 config register stays frozen while unlocked
        do_wr(C_ADR, 16'hFFFF, 16'hFFFF);
        check("R9 C frozen while unlocked", sys_cfg_q, mc);
        check("R9 window closed by C write", unlocked, 0);
        check_regs("R9 nothing else moved");
        check("R11 still set", violation, 1);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0; bus_ext = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        ma = '0; mb = '0; mc = '0;
        check_regs("R1 regs after second reset");
        check("R1 R11 violation cleared", violation, 0);
        check("R1 locked cleared", locked, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule